// File: doc/BRIEF.md
# External Parallel Bus Interface Unit

This unit carries single-word read and write requests from inside the chip out onto an asynchronous parallel bus shared by memories and I/O peripherals. Each request names one of three address spaces (program, data or I/O), an address and, for a write, a data word. The unit runs a fixed-shape external cycle. A setup phase raises nothing but the space select, the address and the direction. A strobe phase follows and may be stretched. A closing phase follows that. Completion is reported on a done pulse that carries the read word.

Two things lengthen the strobe phase. A per-request minimum wait-state count always applies. A ready input from a slow device can add more cycles on top of it. An external DMA master can ask for the bus with a hold request. The unit answers only once it has no cycle in flight. While the answer stands, every bus line it owns floats.

States: `ST_IDLE`, `ST_SETUP`, `ST_STROBE`, `ST_END`, `ST_HOLD`. Transitions:
- `ST_IDLE` goes to `ST_HOLD` when hold is requested. Otherwise it goes to `ST_SETUP` when a request is valid.
- `ST_SETUP` goes to `ST_STROBE` unconditionally.
- `ST_STROBE` goes to `ST_END` when the wait count has reached zero and ready is high.
- `ST_END` goes to `ST_IDLE` unconditionally.
- `ST_HOLD` goes to `ST_IDLE` when hold is withdrawn.

Top module: `ext_bus_unit`

## Requirements
- R1: After reset the unit is idle: all three space selects and both strobes high, `bus_rd_wr` high, `hold_ack`, `busy` and `done` low.
- R2: Space code 0 selects program space (`sel_prog_n`), code 1 and code 3 select data space (`sel_data_n`), and code 2 selects I/O space (`sel_io_n`). The chosen select is low in every cycle from setup through the closing cycle. The other two selects stay high.
- R3: `bus_rd_wr` is low throughout a write cycle and high throughout a read cycle.
- R4: Program and data transfers pulse `mem_stb_n` only, and I/O transfers pulse `io_stb_n` only. The strobe is high in the setup cycle and in the closing cycle, and low in between.
- R5: During a write, `bus_data` carries the write word from setup through the closing cycle. At every other time the unit does not drive `bus_data`.
- R6: The strobe stays low for at least `wait_cfg`+1 cycles, whatever ready does.
- R7: Once the minimum has elapsed, the strobe phase ends on the first cycle in which `bus_ready` is high. With ready low for the first K strobe cycles, the strobe lasts max(`wait_cfg`, K)+1 cycles.
- R8: `done` is high for exactly the closing cycle, together with `busy`. During a read, `rd_data` then holds the word sampled at the end of the strobe phase.
- R9: `hold_ack` rises only from idle, so never while a transfer is open. While it is high, the address, data, select, strobe and direction lines are all undriven.
- R10: A request is taken only when the unit is idle and not holding. Requests during a transfer or a hold are not acted on until then. A hold request wins over a request made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Internal request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | Space code (0 program, 1 data, 2 I/O, 3 data) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| wait_cfg | input | WS_W | Minimum extra strobe cycles, taken in the setup cycle |
| busy | output | 1 | External cycle open |
| done | output | 1 | Closing cycle of a transfer |
| rd_data | output | DATA_W | Last read word |
| bus_addr | output | ADDR_W | External address, floats during hold |
| bus_data | inout | DATA_W | External data |
| sel_prog_n | output | 1 | Program space select, active low |
| sel_data_n | output | 1 | Data space select, active low |
| sel_io_n | output | 1 | I/O space select, active low |
| bus_rd_wr | output | 1 | High for read, low for write |
| mem_stb_n | output | 1 | Memory strobe, active low |
| io_stb_n | output | 1 | I/O strobe, active low |
| bus_ready | input | 1 | Device ready |
| hold_req | input | 1 | External master asks for the bus |
| hold_ack | output | 1 | Bus released to external master |

## Verification
A request taken at clock edge E0 shows setup in the cycle after E0. The strobe is low for the next max(W, K)+1 cycles. `done` and `rd_data` follow in the cycle after that, and the unit is idle one cycle later. The bench drives its inputs and reads the outputs on falling edges. It walks each transfer one cycle at a time from the setup cycle, and counts strobe-low cycles until `done`. It then checks idle one cycle later. For a hold, `hold_ack` is due two cycles after the closing cycle, and idle is due one cycle after `hold_req` falls. Release is observed by having the bench drive the released lines and reading back its own values.

// File: rtl/ebu_pkg.sv
package ebu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_END    = 3'd3,
        ST_HOLD   = 3'd4
    } ebu_state_e;

    typedef enum logic [1:0] {
        SP_PROG = 2'd0,
        SP_DATA = 2'd1,
        SP_IO   = 2'd2,
        SP_ALT  = 2'd3
    } ebu_space_e;

    typedef struct packed {
        logic prog_n;
        logic data_n;
        logic io_n;
    } ebu_sel_t;

    localparam ebu_sel_t SEL_NONE = '{prog_n: 1'b1, data_n: 1'b1, io_n: 1'b1};

    function automatic ebu_sel_t sel_decode(input logic [1:0] sp);
        ebu_sel_t s;
        s = SEL_NONE;
        unique case (ebu_space_e'(sp))
            SP_PROG:        s.prog_n = 1'b0;
            SP_IO:          s.io_n   = 1'b0;
            SP_DATA, SP_ALT: s.data_n = 1'b0;
            default:        s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_io_space(input logic [1:0] sp);
        return ebu_space_e'(sp) == SP_IO;
    endfunction

endpackage

// File: rtl/ebu_wait_ctr.sv
module ebu_wait_ctr #(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WS_W-1:0] load_val,
    input  logic            dec,
    output logic            zero
);
    logic [WS_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ebu_req_reg.sv
module ebu_req_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              in_write,
    input  logic [1:0]        in_space,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_rd,
    output logic              lat_write,
    output logic [1:0]        lat_space,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_space <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_write <= in_write;
            lat_space <= in_space;
            lat_addr  <= in_addr;
            lat_wdata <= in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= bus_rd;
        end
    end

endmodule

// File: rtl/ebu_fsm.sv
module ebu_fsm
    import ebu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       hold_req,
    input  logic       ready,
    input  logic       wait_zero,
    input  logic       lat_write,
    input  logic [1:0] lat_space,
    output logic       accept,
    output logic       ctr_load,
    output logic       ctr_dec,
    output logic       capture,
    output logic       busy,
    output logic       done,
    output logic       hold_ack,
    output logic       drive_data,
    output ebu_sel_t   sel_n,
    output logic       mem_stb_n,
    output logic       io_stb_n,
    output logic       rd_wr
);
    ebu_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        ctr_load = 1'b0;
        ctr_dec  = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (hold_req) begin
                    state_nx = ST_HOLD;
                end else if (req_valid) begin
                    accept   = 1'b1;
                    state_nx = ST_SETUP;
                end
            end
            ST_SETUP: begin
                ctr_load = 1'b1;
                state_nx = ST_STROBE;
            end
            ST_STROBE: begin
                ctr_dec = 1'b1;
                if (wait_zero && ready) begin
                    capture  = !lat_write;
                    state_nx = ST_END;
                end
            end
            ST_END:  state_nx = ST_IDLE;
            ST_HOLD: if (!hold_req) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        sel_n      = SEL_NONE;
        mem_stb_n  = 1'b1;
        io_stb_n   = 1'b1;
        rd_wr      = 1'b1;
        busy       = 1'b0;
        done       = 1'b0;
        hold_ack   = 1'b0;
        drive_data = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SETUP: begin
                sel_n      = sel_decode(lat_space);
                rd_wr      = !lat_write;
                busy       = 1'b1;
                drive_data = lat_write;
            end
            ST_STROBE: begin
                sel_n      = sel_decode(lat_space);
                rd_wr      = !lat_write;
                busy       = 1'b1;
                drive_data = lat_write;
                if (is_io_space(lat_space)) io_stb_n = 1'b0;
                else                        mem_stb_n = 1'b0;
            end
            ST_END: begin
                sel_n      = sel_decode(lat_space);
                rd_wr      = !lat_write;
                busy       = 1'b1;
                done       = 1'b1;
                drive_data = lat_write;
            end
            ST_HOLD: hold_ack = 1'b1;
            default: ;
        endcase
    end

    AST_SETUP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP) |-> ($past(state) == ST_IDLE)); // R10
    AST_HOLD_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> ($past(state) == ST_IDLE)); // R9
    AST_END_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END) |-> $past(ready)); // R7
    AST_END_NEEDS_MIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END) |-> $past(wait_zero)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STROBE) || (state == ST_END)) |-> $stable({sel_n, rd_wr})); // R2

endmodule

// File: rtl/ext_bus_unit.sv
module ext_bus_unit
    import ebu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_space,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WS_W-1:0]   wait_cfg,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output wire  [ADDR_W-1:0] bus_addr,
    inout  wire  [DATA_W-1:0] bus_data,
    output wire               sel_prog_n,
    output wire               sel_data_n,
    output wire               sel_io_n,
    output wire               bus_rd_wr,
    output wire               mem_stb_n,
    output wire               io_stb_n,
    input  logic              bus_ready,
    input  logic              hold_req,
    output logic              hold_ack
);
    logic              accept, ctr_load, ctr_dec, capture, wait_zero, drive_data;
    logic              lat_write;
    logic [1:0]        lat_space;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    ebu_sel_t          sel_int;
    logic              mem_stb_int, io_stb_int, rd_wr_int;
    logic              own_bus;

    ebu_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .in_write(req_write), .in_space(req_space), .in_addr(req_addr),
        .in_wdata(req_wdata), .capture(capture), .bus_rd(bus_data),
        .lat_write(lat_write), .lat_space(lat_space), .lat_addr(lat_addr),
        .lat_wdata(lat_wdata), .rdata(rd_data)
    );

    ebu_wait_ctr #(.WS_W(WS_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(wait_cfg),
        .dec(ctr_dec), .zero(wait_zero)
    );

    ebu_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hold_req(hold_req),
        .ready(bus_ready), .wait_zero(wait_zero), .lat_write(lat_write),
        .lat_space(lat_space), .accept(accept), .ctr_load(ctr_load),
        .ctr_dec(ctr_dec), .capture(capture), .busy(busy), .done(done),
        .hold_ack(hold_ack), .drive_data(drive_data), .sel_n(sel_int),
        .mem_stb_n(mem_stb_int), .io_stb_n(io_stb_int), .rd_wr(rd_wr_int)
    );

    assign own_bus    = !hold_ack;
    assign bus_addr   = own_bus ? lat_addr : {ADDR_W{1'bz}};
    assign bus_data   = (own_bus && drive_data) ? lat_wdata : {DATA_W{1'bz}};
    assign sel_prog_n = own_bus ? sel_int.prog_n : 1'bz;
    assign sel_data_n = own_bus ? sel_int.data_n : 1'bz;
    assign sel_io_n   = own_bus ? sel_int.io_n : 1'bz;
    assign bus_rd_wr  = own_bus ? rd_wr_int : 1'bz;
    assign mem_stb_n  = own_bus ? mem_stb_int : 1'bz;
    assign io_stb_n   = own_bus ? io_stb_int : 1'bz;

    AST_DATA_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        drive_data |-> (lat_write && busy)); // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_stb_int == 1'b0 && io_stb_int == 1'b0)); // R4

endmodule

// File: tb/ext_bus_unit_test.sv
module ext_bus_unit_test;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int WW = 4;
    localparam int NV = 8;
    localparam logic [AW-1:0] DMA_A = 16'h00C3;
    localparam logic [DW-1:0] DMA_D = 16'h5A3C;
    localparam logic [DW-1:0] EXT_D = 16'h3C5A;

    // {write, space[1:0], addr[7:0], wdata[15:0], wait[3:0], ready_low[3:0], strobe_cycles[4:0]}
    localparam logic [39:0] VECS [NV] = '{
        {1'b1, 2'd0, 8'h03, 16'hA5A5, 4'd0, 4'd0, 5'd1},
        {1'b0, 2'd0, 8'h03, 16'h0000, 4'd2, 4'd0, 5'd3},
        {1'b1, 2'd1, 8'h05, 16'h1234, 4'd1, 4'd4, 5'd5},
        {1'b0, 2'd1, 8'h05, 16'h0000, 4'd0, 4'd2, 5'd3},
        {1'b1, 2'd2, 8'h07, 16'hBEEF, 4'd3, 4'd1, 5'd4},
        {1'b0, 2'd2, 8'h07, 16'h0000, 4'd0, 4'd0, 5'd1},
        {1'b1, 2'd3, 8'h09, 16'h0F0F, 4'd2, 4'd2, 5'd3},
        {1'b0, 2'd1, 8'h09, 16'h0000, 4'd5, 4'd3, 5'd6}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_space = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [WW-1:0] wait_cfg = '0;
    logic hold_req = 1'b0;
    logic busy, done, hold_ack;
    logic [DW-1:0] rd_data;
    wire [AW-1:0] bus_addr;
    wire [DW-1:0] bus_data;
    wire sel_prog_n, sel_data_n, sel_io_n, bus_rd_wr, mem_stb_n, io_stb_n;
    logic bus_ready;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int k_cfg = 0;
    int low_cnt = 0;
    logic ext_en = 1'b0;
    logic [DW-1:0] mem [3][16];

    always #10 clk = ~clk;

    ext_bus_unit #(.ADDR_W(AW), .DATA_W(DW), .WS_W(WW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
        .wait_cfg(wait_cfg), .busy(busy), .done(done), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_data(bus_data), .sel_prog_n(sel_prog_n),
        .sel_data_n(sel_data_n), .sel_io_n(sel_io_n), .bus_rd_wr(bus_rd_wr),
        .mem_stb_n(mem_stb_n), .io_stb_n(io_stb_n), .bus_ready(bus_ready),
        .hold_req(hold_req), .hold_ack(hold_ack)
    );

    // external device and external master models
    logic stb_any, dev_rd, dma_en;
    int   sel_idx;
    assign stb_any = (mem_stb_n === 1'b0) || (io_stb_n === 1'b0);
    assign dma_en  = (hold_ack === 1'b1);
    assign sel_idx = (sel_prog_n === 1'b0) ? 0 : (sel_io_n === 1'b0) ? 2 : 1;
    assign dev_rd  = stb_any && (bus_rd_wr === 1'b1) && !dma_en;
    assign bus_ready = (low_cnt >= k_cfg);

    assign bus_data   = dev_rd ? mem[sel_idx][bus_addr[3:0]] :
                        (dma_en ? DMA_D : (ext_en ? EXT_D : {DW{1'bz}}));
    assign bus_addr   = dma_en ? DMA_A : {AW{1'bz}};
    assign sel_prog_n = dma_en ? 1'b0 : 1'bz;
    assign sel_data_n = dma_en ? 1'b0 : 1'bz;
    assign sel_io_n   = dma_en ? 1'b0 : 1'bz;
    assign bus_rd_wr  = dma_en ? 1'b0 : 1'bz;
    assign mem_stb_n  = dma_en ? 1'b0 : 1'bz;
    assign io_stb_n   = dma_en ? 1'b0 : 1'bz;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (stb_any && !dma_en) low_cnt <= low_cnt + 1;
        else                    low_cnt <= 0;
        if (stb_any && !dma_en && bus_rd_wr === 1'b0)
            mem[sel_idx][bus_addr[3:0]] <= bus_data;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        while (cyc < 150000) @(negedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    task automatic run_vec(input logic [39:0] v);
        logic wr; logic [1:0] sp; logic [7:0] ad; logic [15:0] wd;
        logic [3:0] w, k; logic [4:0] en;
        int es, n_low, guard; bit got_done, first, stb_low;
        logic [31:0] bad; logic [2:0] exp_sel; logic [DW-1:0] exp_rd;
        {wr, sp, ad, wd, w, k, en} = v;
        es = (sp == 2'd0) ? 0 : (sp == 2'd2) ? 2 : 1;
        exp_sel = (es == 0) ? 3'b011 : (es == 1) ? 3'b101 : 3'b110;
        exp_rd = mem[es][ad[3:0]];
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_space = sp; req_addr = AW'(ad);
        req_wdata = wd; wait_cfg = w; k_cfg = int'(k);
        @(negedge clk);
        req_valid = 1'b0;
        n_low = 0; bad = '0; first = 1'b1; got_done = 1'b0; guard = 0;
        while (!got_done && guard < 64) begin
            guard++;
            stb_low = (es == 2) ? (io_stb_n == 1'b0) : (mem_stb_n == 1'b0);
            if (!busy) bad[0] = 1'b1;
            if ({sel_prog_n, sel_data_n, sel_io_n} != exp_sel) bad[1] = 1'b1;
            if (bus_rd_wr != !wr) bad[2] = 1'b1;
            if (bus_addr != AW'(ad)) bad[3] = 1'b1;
            if ((es == 2) ? (mem_stb_n == 1'b0) : (io_stb_n == 1'b0)) bad[4] = 1'b1;
            if (first && stb_low) bad[5] = 1'b1;
            if (wr && bus_data != wd) bad[6] = 1'b1;
            if (stb_low) n_low++;
            if (done) begin
                got_done = 1'b1;
                if (stb_low) bad[7] = 1'b1;
                if (!wr) chk(rd_data == exp_rd, "R8 read word", 32'(rd_data), 32'(exp_rd));
            end
            first = 1'b0;
            if (!got_done) @(negedge clk);
        end
        chk(got_done, "R8 done seen", 32'(got_done), 1);
        chk(bad == 0, "R2 R3 R4 R5 cycle shape", bad, 0);
        chk(n_low == int'(en), "R6 R7 strobe length", n_low, 32'(en));
        @(negedge clk);
        chk(!done && !busy && {sel_prog_n, sel_data_n, sel_io_n} == 3'b111,
            "R8 idle after close", {busy, done, sel_prog_n, sel_data_n, sel_io_n}, 32'h07);
        if (wr) chk(mem[es][ad[3:0]] == wd, "R5 write landed", 32'(mem[es][ad[3:0]]), 32'(wd));
    endtask

    initial begin
        int guard; bit bad, saw_done;
        for (int s = 0; s < 3; s++)
            for (int a = 0; a < 16; a++) mem[s][a] = '0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !hold_ack, "R1 status low", {busy, done, hold_ack}, 0);
        chk({sel_prog_n, sel_data_n, sel_io_n, mem_stb_n, io_stb_n, bus_rd_wr} == 6'h3F,
            "R1 bus idle levels", {sel_prog_n, sel_data_n, sel_io_n, mem_stb_n, io_stb_n, bus_rd_wr}, 6'h3F);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk({sel_prog_n, sel_data_n, sel_io_n, mem_stb_n, io_stb_n, bus_rd_wr} == 6'h3F && !busy,
            "R1 idle after reset", {busy, sel_prog_n, sel_data_n, sel_io_n, mem_stb_n, io_stb_n, bus_rd_wr}, 7'h3F);
        // R5 data bus not driven while idle
        ext_en = 1'b1;
        #1 chk(bus_data == EXT_D, "R5 idle data released", 32'(bus_data), 32'(EXT_D));
        ext_en = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: request held high during a transfer and address changed mid-cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_space = 2'd0; req_addr = 16'h0003;
        wait_cfg = 4'd2; k_cfg = 0;
        @(negedge clk);
        req_addr = 16'h000E;
        bad = 1'b0; guard = 0;
        while (!done && guard < 32) begin
            guard++;
            if (bus_addr != 16'h0003) bad = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(!bad && done, "R10 busy ignores new request", 32'(bus_addr), 32'h3);
        @(negedge clk);
        @(negedge clk);
        chk(!busy, "R10 no extra transfer", 32'(busy), 0);

        // R10: hold wins over a same-cycle request
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0001; hold_req = 1'b1;
        @(negedge clk);
        chk(hold_ack && !busy, "R10 hold priority", {hold_ack, busy}, 32'h2);
        req_valid = 1'b0; hold_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !hold_ack, "R10 dropped request not run", {hold_ack, busy}, 0);

        // R9: hold requested during a transfer
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_space = 2'd1; req_addr = 16'h0005;
        wait_cfg = 4'd4; k_cfg = 0;
        @(negedge clk);
        req_valid = 1'b0; hold_req = 1'b1;
        bad = 1'b0; saw_done = 1'b0; guard = 0;
        while (!hold_ack && guard < 32) begin
            guard++;
            if (done) saw_done = 1'b1;
            @(negedge clk);
            if (hold_ack && (busy || !saw_done)) bad = 1'b1;
        end
        chk(hold_ack && !bad && saw_done, "R9 ack after transfer", {hold_ack, bad, saw_done}, 32'h5);
        chk(bus_addr == DMA_A && bus_data == DMA_D, "R9 address and data released",
            {bus_addr, bus_data}, {DMA_A, DMA_D});
        chk({sel_prog_n, sel_data_n, sel_io_n, mem_stb_n, io_stb_n, bus_rd_wr} == 6'h00,
            "R9 controls released", {sel_prog_n, sel_data_n, sel_io_n, mem_stb_n, io_stb_n, bus_rd_wr}, 0);
        req_valid = 1'b1; req_write = 1'b0; req_space = 2'd2; req_addr = 16'h0007; wait_cfg = 4'd0;
        bad = 1'b0;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            if (busy || !hold_ack) bad = 1'b1;
        end
        chk(!bad, "R10 request ignored in hold", 32'(bad), 0);
        hold_req = 1'b0;
        @(negedge clk);
        chk(!hold_ack && !busy, "R9 hold released", {hold_ack, busy}, 0);
        @(negedge clk);
        chk(busy, "R10 request taken after hold", 32'(busy), 1);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 32) begin guard++; @(negedge clk); end
        chk(done && rd_data == 16'hBEEF, "R8 read after hold", 32'(rd_data), 32'hBEEF);
        @(negedge clk);
        finish_run();
    end

endmodule